// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into an FPGA through its passive-serial port. It takes the image as a stream of bytes over a valid/ready handshake. A pulse on `start_i` makes the block drive the active-low program pin low, wait for the device to clear its configuration memory, and release the pin again. It then throws away header bytes until it finds the sync preamble and serializes every byte from that point on a clock/data pin pair. When the stream ends it waits for the device to report completion.

The INIT and DONE feedback pins are sampled only on a millisecond tick, which is derived from the clock-frequency parameter. Each of the three waiting phases has its own timeout and its own error code. The result stays on `ok_o` or `err_o` until the next start.

Top module: `fpga_serial_loader`

## Requirements
- R1: Out of reset and whenever the block is idle, `prog_no`, `cclk_o` and `din_o` are all high and `busy_o` is low.
- R2: A `start_i` pulse while idle makes `busy_o` high and drives `prog_no` low, with `cclk_o` and `din_o` held high. `prog_no` goes high again at the first millisecond tick on which `init_i` is sampled low.
- R3: If `init_i` is still high at tick number `TIMEOUT_MS` of the program-low phase, the block returns to idle with `err_o` = 1.
- R4: After `prog_no` is released, the block waits for `init_i` to be sampled high at a tick. If it is still low at tick number `TIMEOUT_MS`, the block returns to idle with `err_o` = 2.
- R5: During the preamble hunt, `byte_ready_o` is high and every byte offered is consumed. The hunt ends on the fourth 0xFF in a row, and any other byte value resets the run.
- R6: Shifting begins with the four preamble bytes themselves, followed by each later byte, each one sent most significant bit first.
- R7: Each bit lasts 2·`HALF_CYC`+1 cycles: `HALF_CYC` cycles with `cclk_o` low and `din_o` at the bit value, `HALF_CYC` cycles with `cclk_o` high and the same bit, then one cycle with both pins high. Two idle cycles, with both pins high, separate consecutive bytes.
- R8: A byte offered with `byte_last_i` high is the final byte. Once it has been shifted, or at once if it arrives during the hunt, the block starts waiting for DONE.
- R9: If `done_i` is sampled high at a tick, `ok_o` goes high. If it is still low at tick number `TIMEOUT_MS`, `err_o` = 3. Both outcomes return the block to idle.
- R10: INIT and DONE are sampled only on the tick. The tick falls every `CLK_HZ/1000` cycles, counted from entry into each wait phase, so a timeout in the first phase keeps `busy_o` high for exactly `TIMEOUT_MS·CLK_HZ/1000` cycles.
- R11: `ok_o` and `err_o` hold their values until the next accepted start, and `err_o` = 0 means no error. A `start_i` pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run (accepted while idle) |
| byte_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_last_i | input | 1 | Marks the final stream byte |
| byte_ready_o | output | 1 | Block accepts the offered byte |
| prog_no | output | 1 | Program pin, active low |
| cclk_o | output | 1 | Configuration clock pin |
| din_o | output | 1 | Configuration data pin |
| init_i | input | 1 | Device INIT feedback |
| done_i | input | 1 | Device DONE feedback |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run completed |
| err_o | output | 2 | Last run error: 0 none, 1 INIT-low timeout, 2 INIT-high timeout, 3 DONE timeout |

## Verification
Every output is registered. A start is therefore visible on `busy_o` and `prog_no` one cycle after the edge that captures it. A feedback change becomes visible one cycle after the next millisecond tick, never earlier. The serial pins change one cycle after a byte is loaded and then follow a fixed 2·`HALF_CYC`+1 cycle pattern per bit.

The bench keeps a behavioural model that it steps on the same rising edge that the design samples. It compares all outputs at the falling edge, so each result is checked in the exact cycle it is due. Separate checks capture the data bit at each clock rise and compare the result with the expected image. Another check counts the busy cycles of a first-phase timeout.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PROG_LO, S_PROG_HI, S_HUNT, S_LOAD, S_BITS, S_WAIT_DONE
  } state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI, PH_REL} phase_e;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_INIT_LO = 2'd1;
  localparam logic [1:0] ERR_INIT_HI = 2'd2;
  localparam logic [1:0] ERR_DONE    = 2'd3;
endpackage

// File: rtl/fcs_tick.sv
module fcs_tick #(
  parameter int DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      a_r10_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o && !clr_i |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fcs_hunt.sv
module fcs_hunt #(
  parameter int LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output logic       found_o
);
  localparam int RW = $clog2(LEN + 1);

  logic [RW-1:0] run_q;

  assign found_o = take_i && (byte_i == 8'hFF) && (run_q == RW'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (clr_i)   run_q <= '0;
    else if (take_i)  run_q <= (byte_i == 8'hFF) ? run_q + 1'b1 : '0;
  end

  a_r5_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(LEN));
endmodule

// File: rtl/fcs_shift.sv
module fcs_shift
  import fcs_pkg::*;
#(
  parameter int HALF = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       cclk_o,
  output logic       din_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sreg_q;
  logic          half_end;

  assign half_end = (cnt_q == CW'(HALF - 1));
  assign busy_o   = (ph_q != PH_IDLE);
  assign cclk_o   = (ph_q != PH_LO);
  assign din_o    = (ph_q == PH_LO || ph_q == PH_HI) ? sreg_q[7] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sreg_q <= '1;
    end else if (load_i) begin
      ph_q   <= PH_LO;
      cnt_q  <= '0;
      idx_q  <= '0;
      sreg_q <= data_i;
    end else begin
      case (ph_q)
        PH_LO: begin
          cnt_q <= half_end ? '0 : cnt_q + 1'b1;
          if (half_end) ph_q <= PH_HI;
        end
        PH_HI: begin
          cnt_q <= half_end ? '0 : cnt_q + 1'b1;
          if (half_end) ph_q <= PH_REL;
        end
        PH_REL: begin
          if (idx_q == 3'd7) ph_q <= PH_IDLE;
          else begin
            ph_q   <= PH_LO;
            idx_q  <= idx_q + 1'b1;
            sreg_q <= {sreg_q[6:0], 1'b0};
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  a_r7_din_held_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o && !$past(cclk_o) |-> din_o == $past(din_o));
  a_r7_load_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
  import fcs_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 3,
  parameter int HALF_CYC   = 1,
  parameter int SYNC_LEN   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       prog_no,
  output logic       cclk_o,
  output logic       din_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);
  localparam int TICK_DIV = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int MSW      = $clog2(TIMEOUT_MS + 1);
  localparam int RPW      = $clog2(SYNC_LEN + 1);

  state_e         state_q, state_d;
  logic [MSW-1:0] ms_q;
  logic [RPW-1:0] replay_q;
  logic           last_q, ok_q;
  logic [1:0]     err_q, err_set;
  logic           ok_set, tick, ms_last, change;
  logic           take, found, sh_load, sh_busy;
  logic [7:0]     sh_data;

  assign change  = (state_d != state_q);
  assign ms_last = (ms_q == MSW'(TIMEOUT_MS - 1));

  fcs_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i, .rst_ni, .clr_i(change), .tick_o(tick)
  );

  fcs_hunt #(.LEN(SYNC_LEN)) i_hunt (
    .clk_i, .rst_ni, .clr_i(change),
    .take_i(state_q == S_HUNT && take), .byte_i, .found_o(found)
  );

  fcs_shift #(.HALF(HALF_CYC)) i_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .data_i(sh_data),
    .busy_o(sh_busy), .cclk_o, .din_o
  );

  always_comb begin
    state_d      = state_q;
    err_set      = ERR_NONE;
    ok_set       = 1'b0;
    take         = 1'b0;
    sh_load      = 1'b0;
    sh_data      = 8'hFF;
    byte_ready_o = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_PROG_LO;
      S_PROG_LO: if (tick) begin
        if (!init_i)      state_d = S_PROG_HI;
        else if (ms_last) begin state_d = S_IDLE; err_set = ERR_INIT_LO; end
      end
      S_PROG_HI: if (tick) begin
        if (init_i)       state_d = S_HUNT;
        else if (ms_last) begin state_d = S_IDLE; err_set = ERR_INIT_HI; end
      end
      S_HUNT: begin
        byte_ready_o = 1'b1;
        take         = byte_valid_i;
        if (found)                     state_d = S_LOAD;
        else if (take && byte_last_i)  state_d = S_WAIT_DONE;
      end
      S_LOAD: begin
        if (replay_q != '0) begin
          sh_load = 1'b1;
          state_d = S_BITS;
        end else if (last_q) begin
          state_d = S_WAIT_DONE;
        end else begin
          byte_ready_o = 1'b1;
          take         = byte_valid_i;
          sh_data      = byte_i;
          sh_load      = byte_valid_i;
          if (byte_valid_i) state_d = S_BITS;
        end
      end
      S_BITS: if (!sh_busy) state_d = S_LOAD;
      S_WAIT_DONE: if (tick) begin
        if (done_i)       begin state_d = S_IDLE; ok_set = 1'b1; end
        else if (ms_last) begin state_d = S_IDLE; err_set = ERR_DONE; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ms_q     <= '0;
      replay_q <= '0;
      last_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      state_q <= state_d;
      ms_q    <= change ? '0 : (tick ? ms_q + 1'b1 : ms_q);
      if (state_q == S_IDLE && start_i) begin
        ok_q   <= 1'b0;
        err_q  <= ERR_NONE;
        last_q <= 1'b0;
      end else begin
        if (ok_set)             ok_q  <= 1'b1;
        if (err_set != ERR_NONE) err_q <= err_set;
      end
      if (found) begin
        replay_q <= RPW'(SYNC_LEN);
        last_q   <= byte_last_i;
      end else if (state_q == S_LOAD && replay_q != '0) begin
        replay_q <= replay_q - 1'b1;
      end else if (state_q == S_LOAD && take) begin
        last_q   <= byte_last_i;
      end
    end
  end

  assign prog_no = (state_q != S_PROG_LO);
  assign busy_o  = (state_q != S_IDLE);
  assign ok_o    = ok_q;
  assign err_o   = err_q;

  a_r1_idle_pins_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> prog_no && cclk_o && din_o);
  a_r2_prog_low_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> cclk_o && din_o);
  a_r5_ready_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o && prog_no);
  a_r9_ok_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && err_o != ERR_NONE));
  a_r11_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$past(start_i) |-> $stable(ok_o) && $stable(err_o));
endmodule

// File: tb/test_fpga_serial_loader.sv
module test_fpga_serial_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 16000;
  localparam int DIV        = CLK_HZ / 1000;
  localparam int TO         = 3;
  localparam int HALF       = 2;
  localparam int P          = 2 * HALF + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] byte_d = 8'h00;
  logic       valid = 1'b0, last = 1'b0;
  logic       ready, prog_n, cclk, din, busy, ok;
  logic       init = 1'b1, done = 1'b0;
  logic [1:0] err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fpga_serial_loader #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TO), .HALF_CYC(HALF), .SYNC_LEN(4))
  i_fpga_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byte_d),
    .byte_valid_i(valid), .byte_last_i(last), .byte_ready_o(ready),
    .prog_no(prog_n), .cclk_o(cclk), .din_o(din), .init_i(init), .done_i(done),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [8:0] q[$];
  bit init_lo_en, init_hi_en, done_en;
  int icnt = 0;

  // behavioural reference
  int m_state = 0, m_ticks = 0, m_ms = 0, m_run = 0, m_replay = 0, m_t = 0;
  bit m_last = 0, m_ok = 0;
  int m_err = 0;
  logic [7:0] m_byte = 8'hFF;

  // observation
  bit prev_cclk = 1'b1;
  logic [7:0] cap[$];
  logic [7:0] cap_sh = 0;
  int cap_n = 0, rises = 0, busy_cnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_ticks = 0; m_ms = 0; m_run = 0; m_replay = 0; m_t = 0;
      m_last = 0; m_ok = 0; m_err = 0; m_byte = 8'hFF;
    end else begin
      automatic int ns = m_state;
      automatic bit tk = (m_ticks % DIV) == DIV - 1;
      automatic logic [8:0] item;
      case (m_state)
        0: if (start) begin ns = 1; m_ok = 0; m_err = 0; m_last = 0; end
        1: if (tk) begin
             if (!init) ns = 2;
             else if (m_ms == TO - 1) begin ns = 0; m_err = 1; end
             else m_ms++;
           end
        2: if (tk) begin
             if (init) ns = 3;
             else if (m_ms == TO - 1) begin ns = 0; m_err = 2; end
             else m_ms++;
           end
        3: if (valid) begin
             item = q.pop_front();
             m_run = (item[7:0] == 8'hFF) ? m_run + 1 : 0;
             if (m_run == 4) begin ns = 4; m_replay = 4; m_last = item[8]; end
             else if (item[8]) ns = 6;
           end
        4: if (m_replay > 0) begin m_byte = 8'hFF; m_replay--; ns = 5; end
           else if (m_last) ns = 6;
           else if (valid) begin
             item = q.pop_front(); m_byte = item[7:0]; m_last = item[8]; ns = 5;
           end
        5: if (m_t == 8 * P) ns = 4; else m_t++;
        6: if (tk) begin
             if (done) begin ns = 0; m_ok = 1; end
             else if (m_ms == TO - 1) begin ns = 0; m_err = 3; end
             else m_ms++;
           end
        default: ns = 0;
      endcase
      if (ns != m_state) begin m_ticks = 0; m_ms = 0; m_t = 0; m_run = 0; end
      else m_ticks++;
      m_state = ns;
    end
  end

  // compare on every falling edge, then drive environment inputs
  always @(negedge clk) begin
    automatic bit e_cclk = 1, e_din = 1;
    automatic bit e_ready = (m_state == 3) || (m_state == 4 && m_replay == 0 && !m_last);
    if (m_state == 5 && m_t < 8 * P) begin
      automatic int s = m_t % P;
      e_cclk = (s >= HALF);
      e_din  = (s == 2 * HALF) ? 1'b1 : m_byte[7 - m_t / P];
    end
    if (rst_n) begin
      chk("R1", "busy", busy, m_state != 0);
      chk("R2", "prog_n", prog_n, m_state != 1);
      chk("R7", "cclk", cclk, e_cclk);
      chk("R7", "din", din, e_din);
      chk("R5", "ready", ready, e_ready);
      chk("R9", "ok", ok, m_ok);
      chk("R10", "err", err, m_err);  // result due one cycle after its tick
      if (cclk && !prev_cclk) begin
        rises++;
        cap_sh = {cap_sh[6:0], din};
        cap_n++;
        if (cap_n == 8) begin cap.push_back(cap_sh); cap_n = 0; end
      end
      if (busy) busy_cnt++;
    end
    prev_cclk = cclk;
    // device model
    if (!prog_n && init && init_lo_en) begin
      icnt++; if (icnt == 5) begin init = 1'b0; icnt = 0; end
    end else if (prog_n && !init && init_hi_en) begin
      icnt++; if (icnt == 20) begin init = 1'b1; icnt = 0; end
    end else icnt = 0;
    done   = done_en && m_state == 6 && m_ticks >= 7;
    valid  = q.size() > 0;
    byte_d = valid ? q[0][7:0] : 8'h00;
    last   = valid ? q[0][8] : 1'b0;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input bit lo, input bit hi, input bit dn, input bit poke);
    init_lo_en = lo; init_hi_en = hi; done_en = dn;
    @(negedge clk); init = 1'b1;
    rises = 0; cap.delete(); cap_n = 0; busy_cnt = 0;
    pulse_start();
    if (poke) begin
      wait (m_state == 3);
      pulse_start();  // R11: ignored while busy
    end
    wait (m_state == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset prog/cclk/din", {prog_n, cclk, din}, 3'b111);
    chk("R1", "reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 / R10: INIT never falls
    run(0, 0, 0, 0);
    chk("R3", "err init-low timeout", err, 1);
    chk("R10", "busy cycles", busy_cnt, TO * DIV);

    // R4: INIT never returns high
    run(1, 0, 0, 0);
    chk("R4", "err init-high timeout", err, 2);

    // R5 R6 R8 R9: full run with header and a broken preamble
    q = '{9'h000, 9'h0FF, 9'h0FF, 9'h012, 9'h0FF, 9'h0FF, 9'h0FF, 9'h0FF, 9'h0A5, 9'h13C};
    run(1, 1, 1, 1);
    chk("R9", "ok after done", ok, 1);
    chk("R11", "err none", err, 0);
    chk("R6", "bytes shifted", cap.size(), 6);
    chk("R8", "clock rises", rises, 48);
    if (cap.size() == 6) begin
      chk("R6", "byte0", cap[0], 8'hFF);
      chk("R6", "byte3", cap[3], 8'hFF);
      chk("R6", "byte4 msb first", cap[4], 8'hA5);
      chk("R6", "byte5", cap[5], 8'h3C);
    end
    chk("R5", "stream drained", q.size(), 0);

    // R11: status held while idle
    repeat (50) @(negedge clk);
    chk("R11", "ok held", ok, 1);

    // R9: DONE never rises
    q = '{9'h0FF, 9'h0FF, 9'h0FF, 9'h0FF, 9'h181};
    run(1, 1, 0, 0);
    chk("R9", "err done timeout", err, 3);
    chk("R11", "ok cleared by start", ok, 0);
    chk("R8", "clock rises", rises, 40);

    // R8: last byte arrives during hunt
    q = '{9'h055, 9'h0FF, 9'h10A};
    run(1, 1, 1, 0);
    chk("R8", "no clock during hunt end", rises, 0);
    chk("R9", "ok", ok, 1);
    chk("R5", "stream drained", q.size(), 0);

    repeat (20) @(negedge clk);
    chk("R11", "err held", err, 0);
    finish_run();
  end
endmodule